// File: doc/BRIEF.md
# CAN Interrupt Flag Controller

This block sits between a CAN protocol core and a host processor. The core reports eight kinds of event as single-cycle pulses. The block latches each pulse into a flag register, masks the flags with an enable register, and drives a single interrupt line. The host clears a flag by writing a one to its bit. A host handler can therefore acknowledge everything it saw by writing back the value it read.

A write-only command register turns host writes into one-cycle strobes toward the core. A status register gives the host a registered copy of the core's condition bits. One bit of that register is the block's own data-overrun latch, which the matching command strobe clears. When the host releases the receive buffer while frames are still waiting, the receive flag is raised again, so no pending frame goes unannounced.

Top module: `can_irq_ctrl`

## Requirements
- R1: While reset is asserted, the flag register (offset 0x0C) and the enable register (offset 0x10) read 0x00, the status register (offset 0x08) reads 0x3C, and both the interrupt line and all command strobes are low.
- R2: A pulse on `evt_i[i]` sets flag bit i at the next clock edge. The bit map is: 0 receive valid, 1 transmit done, 2 error warning, 3 data overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R3: Writing to offset 0x0C clears every flag bit whose write-data bit is 1 at the next edge and leaves the other bits unchanged. With no write and no event, the flags hold their value.
- R4: If an event pulse and a clearing write hit the same flag bit in the same cycle, the flag is set after the edge.
- R5: Offset 0x10 is a read/write enable register with the same bit map as the flags. `irq_o` is high exactly when some bit is set in both registers, and it follows them without extra delay.
- R6: A write to offset 0x04 drives `cmd_strobe_o[i]` high for exactly the one cycle after the write edge, for each written 1 in bits 0..5. The bit map is: 0 transmit request, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive request, 5 bus-off request. Reads of 0x04 return 0x00.
- R7: Offset 0x08 returns `core_stat_i` as sampled at the previous edge, except bit 1. The input's bit 1 is ignored.
- R8: Status bit 1 is set one edge after a data-overrun event pulse (`evt_i[3]`). It is cleared at the edge where the clear-overrun strobe is high. If the set and the clear occur in the same cycle, the set wins.
- R9: While the release-receive-buffer strobe is high and status bit 0 (receive buffer ready) is 1, flag bit 0 is set at the next edge. If status bit 0 is 0, the strobe leaves the flag untouched.
- R10: Reads of any offset other than 0x04, 0x08, 0x0C and 0x10 return 0x00, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| evt_i | input | 8 | Event pulses from the protocol core |
| core_stat_i | input | 8 | Condition bits from the protocol core |
| cmd_strobe_o | output | 6 | One-cycle command strobes to the core |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The assertions check the following on every cycle:
- the flag set-over-clear priority and write-one-to-clear behaviour;
- that flags hold when nothing touches them;
- that command strobes never last past one cycle without a new write;
- the overrun latch priority and the sampling of the core's status bits;
- the re-raise of the receive flag on release.

Only the bench's scenarios show the following:
- the reset values;
- the enable masking as seen on the interrupt line;
- the exact cycle in which a release re-raises the flag;
- that writes to unmapped offsets leave the enable register unchanged.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    // event / flag bit positions (shared by flag and enable registers)
    localparam int unsigned EV_RXVLD   = 0;
    localparam int unsigned EV_TXDONE  = 1;
    localparam int unsigned EV_WARN    = 2;
    localparam int unsigned EV_OVRUN   = 3;
    localparam int unsigned EV_WAKE    = 4;
    localparam int unsigned EV_PASSIVE = 5;
    localparam int unsigned EV_ARBLOST = 6;
    localparam int unsigned EV_BUSERR  = 7;

    // command strobe positions
    localparam int unsigned CMD_TXREQ  = 0;
    localparam int unsigned CMD_ABORT  = 1;
    localparam int unsigned CMD_REL    = 2;
    localparam int unsigned CMD_CLROVR = 3;
    localparam int unsigned CMD_SELFRX = 4;
    localparam int unsigned CMD_BUSOFF = 5;

    // status positions owned by this block
    localparam int unsigned ST_RXRDY = 0;
    localparam int unsigned ST_OVRUN = 1;

    // register offsets
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_FLAG = 8'h0C;
    localparam logic [7:0] OFS_EN   = 8'h10;

    localparam logic [7:0] STAT_RESET = 8'h3C;
endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
    parameter int unsigned EVT_W  = 8,
    parameter int unsigned RX_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             clr_wr_i,
    input  logic             en_wr_i,
    input  logic [EVT_W-1:0] wdata_i,
    input  logic             rearm_i,
    output logic [EVT_W-1:0] flag_o,
    output logic [EVT_W-1:0] en_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [EVT_W-1:0] flag;
        logic [EVT_W-1:0] en;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [EVT_W-1:0] clr_mask;
    logic [EVT_W-1:0] set_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = clr_wr_i ? wdata_i : '0;
        set_mask = evt_i;
        if (rearm_i) begin
            set_mask[RX_BIT] = 1'b1;
        end
        for (int i = 0; i < int'(EVT_W); i++) begin
            // a set in the same cycle outranks the clear
            st_d.flag[i] = set_mask[i] | (st_q.flag[i] & ~clr_mask[i]);
        end
        if (en_wr_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
    assign irq_o  = |(st_q.flag & st_q.en);

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && ((evt_i & wdata_i) != '0))
        |=> ((flag_o & $past(evt_i & wdata_i)) == $past(evt_i & wdata_i)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && evt_i == '0 && !rearm_i) |=> ((flag_o & $past(wdata_i)) == '0));

    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr_i && evt_i == '0 && !rearm_i) |=> $stable(flag_o));

    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/can_irq_cmd.sv
module can_irq_cmd #(
    parameter int unsigned CMD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic [CMD_W-1:0] wdata_i,
    output logic [CMD_W-1:0] strobe_o
);
    typedef struct packed {
        logic [CMD_W-1:0] strobe;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d.strobe = cmd_wr_i ? wdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

    assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe_o != '0) && !cmd_wr_i) |=> (strobe_o == '0));

    assert_strobe_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_i |=> (strobe_o == $past(wdata_i)));
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status #(
    parameter int unsigned STAT_W    = 8,
    parameter int unsigned OVR_BIT   = 1,
    parameter logic [STAT_W-1:0] RST_VAL = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] core_stat_i,
    input  logic              ovr_set_i,
    input  logic              ovr_clr_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] OVR_MASK = STAT_W'(1) << OVR_BIT;

    typedef struct packed {
        logic [STAT_W-1:0] core;
        logic              ovr;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d.core = core_stat_i & ~OVR_MASK;
        if (ovr_set_i) begin
            st_d.ovr = 1'b1;
        end else if (ovr_clr_i) begin
            st_d.ovr = 1'b0;
        end else begin
            st_d.ovr = st_q.ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.core <= RST_VAL & ~OVR_MASK;
            st_q.ovr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.core | (st_q.ovr ? OVR_MASK : '0);

    assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set_i |=> stat_o[OVR_BIT]);

    assert_ovr_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr_i && !ovr_set_i) |=> !stat_o[OVR_BIT]);

    assert_core_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~OVR_MASK) == ($past(core_stat_i) & ~OVR_MASK)));
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
    import can_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned EVT_W  = 8,
    parameter int unsigned CMD_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [EVT_W-1:0]  core_stat_i,
    output logic [CMD_W-1:0]  cmd_strobe_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);

    logic             wr_cmd, wr_flag, wr_en;
    logic [EVT_W-1:0] flag_w, en_w, stat_w;
    logic [CMD_W-1:0] strobe_w;
    logic             rearm_w;

    assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
    assign wr_flag = reg_wr && (reg_addr == A_FLAG);
    assign wr_en   = reg_wr && (reg_addr == A_EN);

    // release while frames remain queued re-raises the receive flag
    assign rearm_w = strobe_w[CMD_REL] & stat_w[ST_RXRDY];

    can_irq_flags #(
        .EVT_W  (EVT_W),
        .RX_BIT (EV_RXVLD)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_wr_i (wr_flag),
        .en_wr_i  (wr_en),
        .wdata_i  (reg_wdata[EVT_W-1:0]),
        .rearm_i  (rearm_w),
        .flag_o   (flag_w),
        .en_o     (en_w),
        .irq_o    (irq_o)
    );

    can_irq_cmd #(
        .CMD_W (CMD_W)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr_i (wr_cmd),
        .wdata_i  (reg_wdata[CMD_W-1:0]),
        .strobe_o (strobe_w)
    );

    can_irq_status #(
        .STAT_W  (EVT_W),
        .OVR_BIT (ST_OVRUN),
        .RST_VAL (EVT_W'(STAT_RESET))
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_stat_i (core_stat_i),
        .ovr_set_i   (evt_i[EV_OVRUN]),
        .ovr_clr_i   (strobe_w[CMD_CLROVR]),
        .stat_o      (stat_w)
    );

    assign cmd_strobe_o = strobe_w;

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = DATA_W'(stat_w);
            A_FLAG:  reg_rdata = DATA_W'(flag_w);
            A_EN:    reg_rdata = DATA_W'(en_w);
            default: reg_rdata = '0;
        endcase
    end

    assert_cmd_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CMD) |-> (reg_rdata == '0));

    assert_rearm_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_w[CMD_REL] && stat_w[ST_RXRDY]) |=> flag_w[EV_RXVLD]);
endmodule

// File: tb/can_irq_ctrl_tb.sv
module can_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] evt_i = 8'h00;
    logic [7:0] core_stat_i = 8'h00;
    logic [5:0] cmd_strobe_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_irq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_i        (evt_i),
        .core_stat_i  (core_stat_i),
        .cmd_strobe_o (cmd_strobe_o),
        .irq_o        (irq_o)
    );

    typedef struct packed {
        logic [7:0] ev;
        logic       wr;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp_flags;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t TBL [NVEC] = '{
        '{8'h01, 1'b0, 8'h00, 8'h00, 8'h01, 1'b0}, // R2 event, enable still 0
        '{8'h00, 1'b1, 8'h10, 8'h01, 8'h01, 1'b1}, // R5 enable bit 0
        '{8'h82, 1'b0, 8'h00, 8'h00, 8'h83, 1'b1}, // R2 two events
        '{8'h00, 1'b1, 8'h0C, 8'h01, 8'h82, 1'b0}, // R3 clear bit 0 only
        '{8'h00, 1'b1, 8'h10, 8'h80, 8'h82, 1'b1}, // R5 enable bus error
        '{8'h02, 1'b1, 8'h0C, 8'h82, 8'h02, 1'b0}, // R4 set beats clear on bit 1
        '{8'h7C, 1'b0, 8'h00, 8'h00, 8'h7E, 1'b0}, // R2 several events, masked
        '{8'h00, 1'b1, 8'h10, 8'h40, 8'h7E, 1'b1}, // R5 enable arbitration lost
        '{8'h00, 1'b1, 8'h0C, 8'hFF, 8'h00, 1'b0}, // R3 write back everything
        '{8'h00, 1'b1, 8'h20, 8'hFF, 8'h00, 1'b0}, // R10 unmapped write
        '{8'h40, 1'b0, 8'h00, 8'h00, 8'h40, 1'b1}, // R10 enable kept after unmapped write
        '{8'h00, 1'b1, 8'h0C, 8'h40, 8'h00, 1'b0}  // R3 clear last flag
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus, return 1 ns after the edge that took it
    task automatic apply(input logic [7:0] ev, input logic wr,
                         input logic [7:0] a, input logic [7:0] d);
        evt_i     = ev;
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        evt_i  = 8'h00;
        reg_wr = 1'b0;
    endtask

    task automatic idle();
        apply(8'h00, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        // R1: reset state while reset is held
        repeat (3) @(posedge clk);
        #1;
        rd(8'h0C, v); chk("R1 flags in reset", v, 8'h00);
        rd(8'h10, v); chk("R1 enable in reset", v, 8'h00);
        rd(8'h08, v); chk("R1 status in reset", v, 8'h3C);
        chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
        chk("R1 strobes in reset", {2'd0, cmd_strobe_o}, 8'h00);
        rst_n = 1'b1;
        idle();

        // table walk: R2 R3 R4 R5 R10
        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i].ev, TBL[i].wr, TBL[i].addr, TBL[i].wdata);
            rd(8'h0C, v);
            chk($sformatf("R2/R3/R4 table row %0d flags", i), v, TBL[i].exp_flags);
            chk($sformatf("R5 table row %0d irq", i), {7'd0, irq_o}, {7'd0, TBL[i].exp_irq});
        end

        // R10 / R5 readback and unmapped read; R6 command reads zero
        rd(8'h10, v); chk("R10 enable unchanged", v, 8'h40);
        rd(8'h20, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'h04, v); chk("R6 command reads zero", v, 8'h00);

        // R6 / R8: clear overrun (latch set by table row 6)
        rd(8'h08, v); chk("R8 overrun latched", v & 8'h02, 8'h02);
        apply(8'h00, 1'b1, 8'h04, 8'h08);
        chk("R6 clear-overrun strobe", {2'd0, cmd_strobe_o}, 8'h08);
        idle();
        chk("R6 strobe one cycle", {2'd0, cmd_strobe_o}, 8'h00);
        rd(8'h08, v); chk("R8 overrun cleared", v & 8'h02, 8'h00);

        // R7: status sampling, input bit 1 ignored
        core_stat_i = 8'h57;
        idle();
        rd(8'h08, v); chk("R7 status sample", v, 8'h55);

        // R8: overrun event sets latch
        apply(8'h08, 1'b0, 8'h00, 8'h00);
        rd(8'h08, v); chk("R8 overrun set", v, 8'h57);
        // R8: set and clear in the same cycle, set wins
        apply(8'h00, 1'b1, 8'h04, 8'h08);
        apply(8'h08, 1'b0, 8'h00, 8'h00);
        rd(8'h08, v); chk("R8 set beats clear", v & 8'h02, 8'h02);
        idle();
        rd(8'h08, v); chk("R8 latch holds", v & 8'h02, 8'h02);

        // R9: release with frames pending re-raises flag 0 one cycle after strobe
        apply(8'h00, 1'b1, 8'h0C, 8'hFF);
        apply(8'h00, 1'b1, 8'h04, 8'h04);
        rd(8'h0C, v); chk("R9 flag not yet raised", v, 8'h00);
        idle();
        rd(8'h0C, v); chk("R9 flag re-raised", v, 8'h01);

        // R9: release with nothing pending leaves flag alone
        apply(8'h00, 1'b1, 8'h0C, 8'hFF);
        core_stat_i = 8'h54;
        idle();
        apply(8'h00, 1'b1, 8'h04, 8'h04);
        idle();
        rd(8'h0C, v); chk("R9 no re-raise when empty", v, 8'h00);

        // R6: every command bit at once
        apply(8'h00, 1'b1, 8'h04, 8'h3F);
        chk("R6 all strobes", {2'd0, cmd_strobe_o}, 8'h3F);
        idle();
        chk("R6 all strobes drop", {2'd0, cmd_strobe_o}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule